// File: doc/BRIEF.md
# Resistive Touchpanel Measurement Sequencer

This block runs the measurement of a resistive touchpanel through a shared converter. For each measurement it turns on one set of panel drive switches, waits a programmable settling time so the plate voltage can stabilise, then issues a single-cycle start to the converter and waits for its done strobe. The 12-bit value returned is packed with the pen state and a code for what was measured into a 16-bit result word.

Measurements start in one of two ways. In polled mode, software pulses a start input and exactly one measurement follows, or one coordinate pair when pair mode is selected. The result goes to a readback register, and a flag marks it as unread. In continuous mode, a rate timer starts measurements on its own, and each result is pushed out as a one-cycle word for a spare serial-link slot. A hold option in polled mode stops an unread result from being overwritten. The largest settling code switches to a mode with no settling wait, where the chosen drive stays on all the time and pair mode is ignored. A small wake unit watches the pen input while the system sleeps.

Top module: `touch_digitiser`

## Requirements
- R1: After reset, all outputs are low and the readback word is 0x0000.
- R2: A result word holds the pen level in bit 15, the measured source code in bits 14:12, and the converter value in bits 11:0.
- R3: Select code 001 measures X with drive_en bit 0, 010 measures Y with bit 1, and 011 measures pressure with bit 2. With any other code, a poll start is ignored: no drive, no converter start, poll_busy stays low and readback is unchanged. At most one drive_en bit is ever high.
- R4: For delay codes 0 to 14, adc_start rises exactly N+1 cycles after drive_en rises, where N = DLY_UNIT·2^code.
- R5: adc_start is high for one cycle only, and only while a drive_en bit is high. Each measurement issues it once.
- R6: One poll_start pulse gives one measurement. poll_busy is high from the cycle after the pulse until the result is stored, and then rb_valid is high.
- R7: In continuous mode, measurements start by themselves every RATE_UNIT·4^rate cycles, counted from one drive_en rise to the next. Each result appears on slot_word with a one-cycle slot_valid, and the readback word does not change.
- R8: With pair mode set and the select code at X or Y, one trigger measures X and then Y, and gives two results in that order.
- R9: With delay code 15, pair mode is ignored and the selected drive stays on between measurements.
- R10: With hold set, a stored unread result is not overwritten. The waiting result is stored in the cycle of the read strobe. With hold clear, a new result replaces an unread one.
- R11: A read strobe clears rb_valid, except in the cycle where a new result is being stored.
- R12: In full-wake mode, a pen-down rising edge during sleep gives one wake_pulse of one cycle. Without sleep, a pen-down edge gives no pulse.
- R13: In link-only mode, a pen-down rising edge during sleep sets link_hold. link_hold stays high until link_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_cont | input | 1 | 1 = continuous mode, 0 = polled |
| cfg_coord | input | 1 | Pair mode: measure X then Y per trigger |
| cfg_wait | input | 1 | Hold unread readback result |
| cfg_wake_full | input | 1 | 1 = full wake pulse, 0 = link-only hold |
| cfg_sel | input | 3 | Measurement select code |
| cfg_delay | input | 4 | Settling code; 15 = no settling, drive always on |
| cfg_rate | input | 2 | Continuous-mode rate code |
| poll_start | input | 1 | One-cycle software start |
| rd_strobe | input | 1 | Readback register read strobe |
| poll_busy | output | 1 | Polled measurement in progress |
| rb_word | output | 16 | Readback result word |
| rb_valid | output | 1 | Readback result not yet read |
| slot_valid | output | 1 | Slot word valid for one cycle |
| slot_word | output | 16 | Continuous-mode result word |
| drive_en | output | 3 | Panel drive enables {pressure, Y, X} |
| adc_start | output | 1 | Converter start, one cycle |
| adc_done | input | 1 | Converter result ready |
| adc_data | input | 12 | Converter result |
| pen_down | input | 1 | Pen contact level |
| sleep | input | 1 | System asleep |
| link_reset | input | 1 | Clears link_hold |
| wake_pulse | output | 1 | Full wake request |
| link_hold | output | 1 | Link-only wake, hold data line |

## Verification
The bench checks the exact gap between drive and converter start for several delay codes, because an off-by-one settle counter would start the conversion a cycle early or late. It checks the start-to-start spacing in continuous mode: a rate timer that reloaded at the end of each measurement would stretch every period by the measurement time. It reads results at the interface and checks their order. This catches a hold that lets a pending word be overwritten, a pair that comes out in the wrong order, and pair mode that is not forced off by code 15. Invalid select codes and wake edges outside sleep are also tried, to show that a decoder that starts anyway, or a wake that fires while awake, is reported.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    localparam int ADC_W  = 12;
    localparam int WORD_W = 16;

    localparam logic [2:0] SRC_NONE = 3'd0;
    localparam logic [2:0] SRC_X    = 3'd1;
    localparam logic [2:0] SRC_Y    = 3'd2;
    localparam logic [2:0] SRC_Z    = 3'd3;

    localparam logic [3:0] DLY_FORCE = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_STORE  = 2'd3
    } tpd_state_e;

    typedef struct packed {
        logic             pen;
        logic [2:0]       src;
        logic [ADC_W-1:0] val;
    } tpd_word_t;

    typedef struct packed {
        tpd_state_e        st;
        logic [2:0]        src;
        logic              pair;
        logic              second;
        logic              cont;
        logic              busy;
        logic              pend;
        logic              start;
        logic              slot_v;
        logic [WORD_W-1:0] slot_w;
        logic [WORD_W-1:0] rb;
        logic [ADC_W-1:0]  data;
    } tpd_regs_t;

    function automatic logic src_valid(input logic [2:0] s);
        return (s == SRC_X) || (s == SRC_Y) || (s == SRC_Z);
    endfunction

    function automatic logic [2:0] drive_of(input logic [2:0] s);
        logic [2:0] d;
        case (s)
            SRC_X:   d = 3'b001;
            SRC_Y:   d = 3'b010;
            SRC_Z:   d = 3'b100;
            default: d = 3'b000;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tpd_settle.sv
module tpd_settle #(
    parameter int DLY_UNIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       run,
    input  logic [3:0] code,
    output logic       expired
);
    import tpd_pkg::*;

    localparam int MAX_TICKS = DLY_UNIT << 14;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] ticks;

    always_comb begin
        if (code == DLY_FORCE) begin
            ticks = '0;
        end else begin
            ticks = CNT_W'(DLY_UNIT) << code;
        end
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = ticks;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: counter steps down by one per running cycle
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: a load is never already expired unless the code asks for zero ticks
    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code != DLY_FORCE) |=> !expired);

endmodule

// File: rtl/tpd_rate.sv
module tpd_rate #(
    parameter int RATE_UNIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload,
    input  logic [1:0] rate,
    output logic       due
);
    localparam int MAX_P = RATE_UNIT << 6;
    localparam int CW    = $clog2(MAX_P + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] period;

    always_comb begin
        period = CW'(RATE_UNIT) << {rate, 1'b0};
        cnt_d  = cnt_q;
        if (reload) begin
            cnt_d = period - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign due = (cnt_q == '0);

    // R7: a start reloads a full period, so the next start is not due at once
    a_r7_reload_not_due: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !due);

endmodule

// File: rtl/tpd_wake.sv
module tpd_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic pen_down,
    input  logic full_mode,
    input  logic link_reset,
    output logic wake_pulse,
    output logic link_hold
);
    typedef struct packed {
        logic pen;
        logic hold;
        logic pulse;
    } wake_regs_t;

    wake_regs_t w_d, w_q;
    logic       rise;

    always_comb begin
        rise      = pen_down && !w_q.pen;
        w_d       = w_q;
        w_d.pen   = pen_down;
        w_d.pulse = sleep && rise && full_mode;
        if (link_reset) begin
            w_d.hold = 1'b0;
        end else if (sleep && rise && !full_mode) begin
            w_d.hold = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign wake_pulse = w_q.pulse;
    assign link_hold  = w_q.hold;

    // R12: the wake request lasts one cycle
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R12: a wake request only follows a cycle spent asleep
    a_r12_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> $past(sleep));

    // R13: the link hold stays until the link reset
    a_r13_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (link_hold && !link_reset) |=> link_hold);

endmodule

// File: rtl/touch_digitiser.sv
module touch_digitiser #(
    parameter int DLY_UNIT  = 1,
    parameter int RATE_UNIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_cont,
    input  logic        cfg_coord,
    input  logic        cfg_wait,
    input  logic        cfg_wake_full,
    input  logic [2:0]  cfg_sel,
    input  logic [3:0]  cfg_delay,
    input  logic [1:0]  cfg_rate,
    input  logic        poll_start,
    input  logic        rd_strobe,
    output logic        poll_busy,
    output logic [15:0] rb_word,
    output logic        rb_valid,
    output logic        slot_valid,
    output logic [15:0] slot_word,
    output logic [2:0]  drive_en,
    output logic        adc_start,
    input  logic        adc_done,
    input  logic [11:0] adc_data,
    input  logic        pen_down,
    input  logic        sleep,
    input  logic        link_reset,
    output logic        wake_pulse,
    output logic        link_hold
);
    import tpd_pkg::*;

    tpd_regs_t r_d, r_q;

    logic      settle_load;
    logic      settle_expired;
    logic      rate_reload;
    logic      rate_due;
    logic      force_on;
    logic      pair_eff;
    logic      sel_ok;
    logic      do_store;
    tpd_word_t word;

    tpd_settle #(.DLY_UNIT(DLY_UNIT)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .run     (r_q.st == ST_SETTLE),
        .code    (cfg_delay),
        .expired (settle_expired)
    );

    tpd_rate #(.RATE_UNIT(RATE_UNIT)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (rate_reload),
        .rate   (cfg_rate),
        .due    (rate_due)
    );

    tpd_wake u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .pen_down   (pen_down),
        .full_mode  (cfg_wake_full),
        .link_reset (link_reset),
        .wake_pulse (wake_pulse),
        .link_hold  (link_hold)
    );

    always_comb begin
        force_on = (cfg_delay == DLY_FORCE);
        pair_eff = cfg_coord && !force_on && ((cfg_sel == SRC_X) || (cfg_sel == SRC_Y));
        sel_ok   = src_valid(cfg_sel);

        word.pen = pen_down;
        word.src = r_q.src;
        word.val = r_q.data;

        r_d         = r_q;
        r_d.start   = 1'b0;
        r_d.slot_v  = 1'b0;
        settle_load = 1'b0;
        rate_reload = 1'b0;
        do_store    = 1'b0;

        if (poll_start && sel_ok && !cfg_cont) begin
            r_d.busy = 1'b1;
        end
        if (rd_strobe) begin
            r_d.pend = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (sel_ok && ((cfg_cont && rate_due) || (!cfg_cont && r_q.busy))) begin
                    r_d.st      = ST_SETTLE;
                    r_d.src     = pair_eff ? SRC_X : cfg_sel;
                    r_d.pair    = pair_eff;
                    r_d.second  = 1'b0;
                    r_d.cont    = cfg_cont;
                    settle_load = 1'b1;
                    rate_reload = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_expired) begin
                    r_d.st    = ST_CONV;
                    r_d.start = 1'b1;
                end
            end
            ST_CONV: begin
                if (adc_done) begin
                    r_d.data = adc_data;
                    r_d.st   = ST_STORE;
                end
            end
            ST_STORE: begin
                if (r_q.cont) begin
                    r_d.slot_v = 1'b1;
                    r_d.slot_w = word;
                    do_store   = 1'b1;
                end else if (!cfg_wait || !r_q.pend || rd_strobe) begin
                    r_d.rb   = word;
                    r_d.pend = 1'b1;
                    do_store = 1'b1;
                end
                if (do_store) begin
                    if (r_q.pair && !r_q.second) begin
                        r_d.src     = SRC_Y;
                        r_d.second  = 1'b1;
                        r_d.st      = ST_SETTLE;
                        settle_load = 1'b1;
                    end else begin
                        r_d.st = ST_IDLE;
                        if (!r_q.cont) begin
                            r_d.busy = 1'b0;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if ((r_q.st == ST_SETTLE) || (r_q.st == ST_CONV)) begin
            drive_en = drive_of(r_q.src);
        end else if (force_on) begin
            drive_en = drive_of(cfg_sel);
        end else begin
            drive_en = 3'b000;
        end
    end

    assign adc_start  = r_q.start;
    assign poll_busy  = r_q.busy;
    assign rb_word    = r_q.rb;
    assign rb_valid   = r_q.pend;
    assign slot_valid = r_q.slot_v;
    assign slot_word  = r_q.slot_w;

    // R5: the converter start lasts a single cycle
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R5: a start is only issued while the panel is driven
    a_r5_start_driven: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (drive_en != 3'b000));

    // R3: never more than one drive set on
    a_r3_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_en));

    // R10: an unread word under hold is left alone unless read
    a_r10_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait && rb_valid && !rd_strobe) |=> $stable(rb_word));

    // R6: busy only drops once a result sits in readback
    a_r6_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(poll_busy) |-> rb_valid);

    // R11: a read outside a store leaves nothing pending
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && r_q.st != ST_STORE) |=> !rb_valid);

endmodule

// File: tb/touch_digitiser_bench.sv
`timescale 1ns/1ps
module touch_digitiser_bench;

    localparam int DLY_UNIT  = 1;
    localparam int RATE_UNIT = 64;
    localparam int ADC_LAT   = 3;
    localparam int WDOG      = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_cont, cfg_coord, cfg_wait, cfg_wake_full;
    logic [2:0]  cfg_sel;
    logic [3:0]  cfg_delay;
    logic [1:0]  cfg_rate;
    logic        poll_start, rd_strobe;
    logic        poll_busy;
    logic [15:0] rb_word;
    logic        rb_valid;
    logic        slot_valid;
    logic [15:0] slot_word;
    logic [2:0]  drive_en;
    logic        adc_start;
    logic        adc_done;
    logic [11:0] adc_data;
    logic        pen_down, sleep, link_reset;
    logic        wake_pulse, link_hold;

    always #5 clk = ~clk;

    touch_digitiser #(.DLY_UNIT(DLY_UNIT), .RATE_UNIT(RATE_UNIT)) u_touch_digitiser (
        .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_coord(cfg_coord),
        .cfg_wait(cfg_wait), .cfg_wake_full(cfg_wake_full), .cfg_sel(cfg_sel),
        .cfg_delay(cfg_delay), .cfg_rate(cfg_rate), .poll_start(poll_start),
        .rd_strobe(rd_strobe), .poll_busy(poll_busy), .rb_word(rb_word),
        .rb_valid(rb_valid), .slot_valid(slot_valid), .slot_word(slot_word),
        .drive_en(drive_en), .adc_start(adc_start), .adc_done(adc_done),
        .adc_data(adc_data), .pen_down(pen_down), .sleep(sleep),
        .link_reset(link_reset), .wake_pulse(wake_pulse), .link_hold(link_hold)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [11:0] data_q[$];
    logic [11:0] next_data = 12'h0A5;
    int          adc_cd = 0;
    int          cyc = 0;
    int          since_en = 0;
    logic [2:0]  prev_en = 3'b000;
    int          last_rise = -1;
    int          n_res = 0;
    int          n_starts = 0;
    int          n_wake = 0;
    logic [15:0] rb_prev = 16'h0000;
    logic [2:0]  fixed_src = 3'd1;
    bit          alt_mode = 0;
    bit          alt_x = 1;
    bit          rate_chk = 0;
    bit          cont_tb = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic expect_word(input logic [15:0] got, input string req);
        logic [2:0]  s;
        logic [11:0] d;
        logic [15:0] e;
        if (alt_mode) begin
            s     = alt_x ? 3'd1 : 3'd2;
            alt_x = !alt_x;
        end else begin
            s = fixed_src;
        end
        d = (data_q.size() > 0) ? data_q.pop_front() : 12'hxxx;
        e = {pen_down, s, d};
        check(got === e, req, "result word", {16'h0, got}, {16'h0, e});
    endtask

    function automatic int period_of(input logic [1:0] r);
        return RATE_UNIT << (2 * r);
    endfunction

    // per-clock reference model and monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cyc > WDOG) begin
                check(0, "WDOG", "watchdog expired", cyc, WDOG);
                finish_run();
            end
            // ADC model
            adc_done = (adc_cd == 1);
            if (adc_cd == 1) begin
                adc_data = next_data;
                data_q.push_back(next_data);
                next_data = next_data + 12'h13B;
            end
            if (adc_cd > 0) adc_cd--;
            // drive tracking
            if (drive_en != prev_en) begin
                if (drive_en != 3'b000 && prev_en == 3'b000 && rate_chk) begin
                    if (last_rise >= 0)
                        check(cyc - last_rise == period_of(cfg_rate), "R7", "start spacing",
                              cyc - last_rise, period_of(cfg_rate));
                    last_rise = cyc;
                end
                since_en = 0;
                prev_en  = drive_en;
            end else begin
                since_en++;
            end
            if (adc_start) begin
                n_starts++;
                adc_cd = ADC_LAT;
                check(drive_en != 3'b000, "R5", "start while driven", drive_en, 1);
                if (cfg_delay != 4'hF)
                    check(since_en == (DLY_UNIT << cfg_delay) + 1, "R4", "settle gap",
                          since_en, (DLY_UNIT << cfg_delay) + 1);
            end
            if (slot_valid) begin
                n_res++;
                expect_word(slot_word, "R7");
            end
            if (rb_word !== rb_prev) begin
                n_res++;
                check(!cont_tb, "R7", "readback untouched in continuous", rb_word, rb_prev);
                expect_word(rb_word, "R2");
                rb_prev = rb_word;
            end
            if (wake_pulse) n_wake++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1 poll_start = 1'b1;
        @(negedge clk); #1 poll_start = 1'b0;
    endtask

    task automatic pulse_read();
        @(negedge clk); #1 rd_strobe = 1'b1;
        @(negedge clk); #1 rd_strobe = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (poll_busy && t < 20000) begin
            @(negedge clk); t++;
        end
        #1;
        check(!poll_busy, req, "busy cleared", poll_busy, 0);
    endtask

    initial begin
        int base;
        int st0;
        logic [15:0] held;
        rst_n = 0; cfg_cont = 0; cfg_coord = 0; cfg_wait = 0; cfg_wake_full = 0;
        cfg_sel = 3'd1; cfg_delay = 4'd3; cfg_rate = 2'd0;
        poll_start = 0; rd_strobe = 0; adc_done = 0; adc_data = 12'h000;
        pen_down = 0; sleep = 0; link_reset = 0;
        repeat (4) @(negedge clk);
        #1 rst_n = 1;
        tick(1);

        // R1 reset state
        check(rb_word == 16'h0000, "R1", "rb_word", rb_word, 0);
        check(!rb_valid && !poll_busy && !slot_valid, "R1", "flags",
              {rb_valid, poll_busy, slot_valid}, 0);
        check(drive_en == 3'b000 && !adc_start, "R1", "drive/start", {drive_en, adc_start}, 0);
        check(!wake_pulse && !link_hold, "R1", "wake", {wake_pulse, link_hold}, 0);

        // R6, R2, R4: one polled X measurement, pen down
        pen_down = 1; fixed_src = 3'd1; alt_mode = 0;
        base = n_res; st0 = n_starts;
        pulse_start();
        check(poll_busy, "R6", "busy after start", poll_busy, 1);
        wait_idle("R6");
        check(rb_valid, "R6", "pending after store", rb_valid, 1);
        tick(60);
        check(n_res - base == 1 && n_starts - st0 == 1, "R6", "one measurement",
              n_starts - st0, 1);

        // R11, R3 pressure with zero-code delay, pen up
        pulse_read();
        check(!rb_valid, "R11", "read clears pending", rb_valid, 0);
        pen_down = 0; cfg_sel = 3'd3; cfg_delay = 4'd0; fixed_src = 3'd3;
        base = n_res;
        pulse_start();
        wait_idle("R3");
        tick(2);
        check(n_res - base == 1, "R3", "pressure result", n_res - base, 1);

        // R3 invalid select codes ignored
        cfg_sel = 3'd0; held = rb_word; st0 = n_starts;
        pulse_start(); tick(40);
        check(!poll_busy && n_starts == st0 && rb_word == held, "R3", "code 000 ignored",
              n_starts - st0, 0);
        cfg_sel = 3'd5;
        pulse_start(); tick(40);
        check(!poll_busy && n_starts == st0 && drive_en == 3'b000, "R3", "code 101 ignored",
              {poll_busy, drive_en}, 0);

        // R8 pair mode: X then Y
        cfg_sel = 3'd1; cfg_coord = 1; cfg_delay = 4'd1; alt_mode = 1; alt_x = 1;
        base = n_res;
        pulse_start();
        wait_idle("R8");
        tick(2);
        check(n_res - base == 2, "R8", "pair gives two results", n_res - base, 2);
        alt_mode = 0;

        // R9 code 15: drive held, pair mode ignored
        cfg_sel = 3'd2; cfg_delay = 4'hF; fixed_src = 3'd2;
        tick(3);
        check(drive_en == 3'b010, "R9", "drive held in idle", drive_en, 3'b010);
        base = n_res;
        pulse_start();
        wait_idle("R9");
        tick(20);
        check(n_res - base == 1, "R9", "pair forced off", n_res - base, 1);
        check(drive_en == 3'b010, "R9", "drive still held", drive_en, 3'b010);
        cfg_coord = 0;

        // R10 hold: pending result not overwritten
        cfg_sel = 3'd1; cfg_delay = 4'd2; fixed_src = 3'd1; cfg_wait = 1;
        tick(2);
        pulse_read();
        pulse_start(); wait_idle("R10");
        held = rb_word; base = n_res;
        pulse_start(); tick(80);
        check(poll_busy && rb_valid, "R10", "stalled while unread", {poll_busy, rb_valid}, 3);
        check(rb_word == held, "R10", "word kept", rb_word, held);
        pulse_read();
        tick(2);
        check(!poll_busy && n_res - base == 1, "R10", "stored on read", n_res - base, 1);
        cfg_wait = 0; base = n_res;
        pulse_start(); wait_idle("R10"); tick(2);
        check(n_res - base == 1 && rb_valid, "R10", "overwrite without hold", n_res - base, 1);

        // R7 continuous, rate 0 then rate 1
        pulse_read();
        held = rb_word; base = n_res;
        cont_tb = 1; rate_chk = 1; last_rise = -1;
        cfg_cont = 1;
        begin
            int t = 0;
            while (n_res - base < 6 && t < 3000) begin tick(1); t++; end
        end
        check(n_res - base >= 6, "R7", "slot results", n_res - base, 6);
        cfg_cont = 0; tick(100);
        cfg_rate = 2'd1; last_rise = -1; base = n_res;
        cfg_cont = 1;
        begin
            int t = 0;
            while (n_res - base < 3 && t < 3000) begin tick(1); t++; end
        end
        check(n_res - base >= 3, "R7", "slot results at rate 1", n_res - base, 3);
        cfg_cont = 0; tick(100);
        rate_chk = 0; cont_tb = 0;
        check(rb_word == held, "R7", "readback unchanged", rb_word, held);

        // R12 wake: not asleep gives nothing, asleep full gives one pulse
        cfg_wake_full = 1; pen_down = 0; tick(3);
        n_wake = 0; pen_down = 1; tick(10);
        check(n_wake == 0, "R12", "no wake while awake", n_wake, 0);
        pen_down = 0; sleep = 1; tick(3);
        pen_down = 1; tick(10);
        check(n_wake == 1, "R12", "one wake pulse", n_wake, 1);
        check(!link_hold, "R12", "no link hold in full mode", link_hold, 0);

        // R13 link-only hold
        cfg_wake_full = 0; pen_down = 0; tick(3);
        pen_down = 1; tick(3);
        check(link_hold, "R13", "hold set", link_hold, 1);
        tick(20);
        check(link_hold, "R13", "hold kept", link_hold, 1);
        link_reset = 1; tick(1); link_reset = 0; tick(2);
        check(!link_hold, "R13", "hold cleared", link_hold, 0);
        sleep = 0;

        tick(5);
        finish_run();
    end

endmodule